// File: doc/BRIEF.md
# MESI Snooping Line-State Controller

This block keeps the coherence state of every line in one private, direct-mapped cache that shares a snooping bus with other caches. It follows a write-invalidate MESI protocol. Two kinds of event drive it: requests from its own core (read or write of a line address) and transactions snooped from other caches (a bus read, or a read-for-ownership/invalidate). For each event it works out whether the line is present, what the line's next state is, and which bus transaction, if any, must go out. When a snoop hits a dirty line, it raises a flush request. When a core miss displaces a dirty victim, it raises a write-back request that carries the victim's line address.

On a core read miss, the block samples a shared-line input. This input says whether some other cache already holds the line, and it decides whether the line is installed Exclusive or Shared. A small tag array and a state array, indexed by the low bits of the line address, sit inside the block so that hit and miss results can be observed. Bus arbitration, data movement and memory are handled elsewhere. A core request and a snoop can arrive in the same cycle. All results are registered and appear one cycle after the request.

Top module: `mesi_snoop_ctrl`

## Requirements
- R1: After synchronous reset every line is Invalid, all outputs are zero, and the first core access to any address misses.
- R2: A core request presented with `cpu_valid` gives `rsp_valid` one cycle later, together with `rsp_hit` and the line's resulting state on `rsp_state`, encoded Invalid=0, Shared=1, Exclusive=2, Modified=3. `bus_addr` echoes the request address.
- R3: A core read miss issues `bus_cmd`=1 (bus read) and installs the tag. The line becomes Exclusive (2) when `cpu_shared` is low and Shared (1) when it is high.
- R4: A core read that hits a line in Modified, Exclusive or Shared leaves the state unchanged and issues `bus_cmd`=0.
- R5: A core write that hits a line in Exclusive or Modified leaves the line Modified and issues no bus transaction (`bus_cmd`=0).
- R6: A core write that hits a Shared line, or that misses, leaves the line Modified and issues `bus_cmd`=2 (read-for-ownership/invalidate).
- R7: A snoop with `snp_op`=1 (bus read) that hits a valid line sets `snp_hit`, and the line becomes Shared.
- R8: A snoop with `snp_op`=2 (read-for-ownership/invalidate) that hits a valid line sets `snp_hit`, and the line becomes Invalid.
- R9: `snp_cmd` is 3 (flush) exactly when a snoop hits a Modified line, and 0 otherwise. A snoop that misses, or that carries `snp_op` 0 or 3, reports no hit and changes no state.
- R10: A core miss whose indexed line is Modified under a different tag raises `wb_valid`, with `wb_addr` equal to the victim's line address. No other request raises `wb_valid`.
- R11: When a snoop and a core request address the same index in one cycle, the snoop's state change is applied first, and the core request is judged against the state the snoop leaves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_valid | input | 1 | Core request present |
| cpu_write | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Core line address (tag above index) |
| cpu_shared | input | 1 | Shared-line input, sampled on a read miss |
| snp_valid | input | 1 | Snooped transaction present |
| snp_op | input | 2 | Snooped code: 1 bus read, 2 read-for-ownership/invalidate |
| snp_addr | input | ADDR_W | Snooped line address |
| rsp_valid | output | 1 | Core result valid |
| rsp_hit | output | 1 | Core request hit |
| rsp_state | output | 2 | Line state after the core request |
| bus_cmd | output | 2 | Transaction to issue: 0 none, 1 read, 2 read-for-ownership |
| bus_addr | output | ADDR_W | Address for `bus_cmd` |
| wb_valid | output | 1 | Dirty victim must be written back |
| wb_addr | output | ADDR_W | Victim line address |
| snp_rsp_valid | output | 1 | Snoop result valid |
| snp_hit | output | 1 | Snoop found a valid copy here |
| snp_cmd | output | 2 | 3 = flush the dirty copy, else 0 |

## Verification
A snoop and a core request can land on the same line in the same cycle, and the snoop must take effect first. The sweep provokes this by aiming the snoop at the core's index half the time, with only two tags in play, so that the two events coincide again and again across every state. The bench model applies the snoop's transition to its own copy of the line before it classifies the core request. A wrong ordering therefore shows up as a mismatch in the reported hit, state or bus command.

// File: rtl/mesi_snoop_pkg.sv
package mesi_snoop_pkg;
  typedef enum logic [1:0] {
    ST_I = 2'd0,
    ST_S = 2'd1,
    ST_E = 2'd2,
    ST_M = 2'd3
  } line_st_t;

  typedef enum logic [1:0] {
    CMD_NONE  = 2'd0,
    CMD_RD    = 2'd1,
    CMD_RDX   = 2'd2,
    CMD_FLUSH = 2'd3
  } bus_cmd_t;
endpackage

// File: rtl/mesi_line_store.sv
module mesi_line_store
  import mesi_snoop_pkg::*;
#(
  parameter int IDX_W = 3,
  parameter int TAG_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] s_idx,
  output line_st_t         s_st,
  output logic [TAG_W-1:0] s_tag,
  input  logic [IDX_W-1:0] c_idx,
  output line_st_t         c_st,
  output logic [TAG_W-1:0] c_tag,
  input  logic             s_we,
  input  line_st_t         s_wst,
  input  logic             c_we,
  input  line_st_t         c_wst,
  input  logic [TAG_W-1:0] c_wtag
);
  localparam int LINES = 1 << IDX_W;

  line_st_t         st_q    [LINES];
  logic [TAG_W-1:0] tag_mem [LINES];

  // state kept in flops: needs reset and two writers per cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < LINES; i++) st_q[i] <= ST_I;
    end else begin
      if (s_we) st_q[s_idx] <= s_wst;
      if (c_we) st_q[c_idx] <= c_wst;  // core result already includes snoop
    end
  end

  // tags: single write port, no reset, RAM-inferable
  always_ff @(posedge clk) begin
    if (c_we) tag_mem[c_idx] <= c_wtag;
  end

  assign s_st  = st_q[s_idx];
  assign s_tag = tag_mem[s_idx];
  assign c_st  = st_q[c_idx];
  assign c_tag = tag_mem[c_idx];
endmodule

// File: rtl/mesi_snoop_xform.sv
module mesi_snoop_xform
  import mesi_snoop_pkg::*;
(
  input  logic       act,
  input  logic [1:0] op,
  input  line_st_t   cur,
  input  logic       tag_eq,
  output logic       hit,
  output line_st_t   nxt,
  output logic       flush
);
  always_comb begin
    hit   = act && (cur != ST_I) && tag_eq;
    flush = hit && (cur == ST_M);
    if (!hit)                       nxt = cur;
    else if (op == 2'(CMD_RD))      nxt = ST_S;
    else                            nxt = ST_I;
  end
endmodule

// File: rtl/mesi_cpu_xform.sv
module mesi_cpu_xform
  import mesi_snoop_pkg::*;
(
  input  logic     write,
  input  logic     shared_in,
  input  line_st_t cur,
  input  logic     tag_eq,
  output logic     hit,
  output line_st_t nxt,
  output bus_cmd_t cmd,
  output logic     evict
);
  always_comb begin
    hit   = (cur != ST_I) && tag_eq;
    evict = !hit && (cur == ST_M);
    if (write) begin
      nxt = ST_M;
      cmd = (hit && (cur == ST_E || cur == ST_M)) ? CMD_NONE : CMD_RDX;
    end else if (hit) begin
      nxt = cur;
      cmd = CMD_NONE;
    end else begin
      nxt = shared_in ? ST_S : ST_E;
      cmd = CMD_RD;
    end
  end
endmodule

// File: rtl/mesi_snoop_ctrl.sv
module mesi_snoop_ctrl
  import mesi_snoop_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_valid,
  input  logic              cpu_write,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_shared,
  input  logic              snp_valid,
  input  logic [1:0]        snp_op,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [1:0]        rsp_state,
  output logic [1:0]        bus_cmd,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              wb_valid,
  output logic [ADDR_W-1:0] wb_addr,
  output logic              snp_rsp_valid,
  output logic              snp_hit,
  output logic [1:0]        snp_cmd
);
  localparam int TAG_W = ADDR_W - IDX_W;

  logic [IDX_W-1:0] s_idx, c_idx;
  logic [TAG_W-1:0] s_tag, c_tag, s_tag_q, c_tag_q;
  line_st_t         s_st, c_st_raw, c_pre, s_nxt, c_nxt;
  logic             s_act, s_hit, s_flush, c_hit, c_evict;
  bus_cmd_t         c_cmd;

  assign s_idx = snp_addr[IDX_W-1:0];
  assign s_tag = snp_addr[ADDR_W-1:IDX_W];
  assign c_idx = cpu_addr[IDX_W-1:0];
  assign c_tag = cpu_addr[ADDR_W-1:IDX_W];
  assign s_act = snp_valid && (snp_op == 2'(CMD_RD) || snp_op == 2'(CMD_RDX));

  mesi_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_store (
    .clk    (clk),
    .rst    (rst),
    .s_idx  (s_idx),
    .s_st   (s_st),
    .s_tag  (s_tag_q),
    .c_idx  (c_idx),
    .c_st   (c_st_raw),
    .c_tag  (c_tag_q),
    .s_we   (s_hit),
    .s_wst  (s_nxt),
    .c_we   (cpu_valid),
    .c_wst  (c_nxt),
    .c_wtag (c_tag)
  );

  mesi_snoop_xform u_snp (
    .act    (s_act),
    .op     (snp_op),
    .cur    (s_st),
    .tag_eq (s_tag_q == s_tag),
    .hit    (s_hit),
    .nxt    (s_nxt),
    .flush  (s_flush)
  );

  // snoop first: the core sees the state the snoop leaves behind
  assign c_pre = (s_hit && (s_idx == c_idx)) ? s_nxt : c_st_raw;

  mesi_cpu_xform u_cpu (
    .write     (cpu_write),
    .shared_in (cpu_shared),
    .cur       (c_pre),
    .tag_eq    (c_tag_q == c_tag),
    .hit       (c_hit),
    .nxt       (c_nxt),
    .cmd       (c_cmd),
    .evict     (c_evict)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid     <= 1'b0;
      rsp_hit       <= 1'b0;
      rsp_state     <= 2'(ST_I);
      bus_cmd       <= 2'(CMD_NONE);
      bus_addr      <= '0;
      wb_valid      <= 1'b0;
      wb_addr       <= '0;
      snp_rsp_valid <= 1'b0;
      snp_hit       <= 1'b0;
      snp_cmd       <= 2'(CMD_NONE);
    end else begin
      rsp_valid     <= cpu_valid;
      rsp_hit       <= cpu_valid && c_hit;
      rsp_state     <= cpu_valid ? 2'(c_nxt) : 2'(ST_I);
      bus_cmd       <= cpu_valid ? 2'(c_cmd) : 2'(CMD_NONE);
      bus_addr      <= cpu_addr;
      wb_valid      <= cpu_valid && c_evict;
      wb_addr       <= {c_tag_q, c_idx};
      snp_rsp_valid <= snp_valid;
      snp_hit       <= s_hit;
      snp_cmd       <= s_flush ? 2'(CMD_FLUSH) : 2'(CMD_NONE);
    end
  end
endmodule

// File: rtl/mesi_snoop_ctrl_chk.sv
module mesi_snoop_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       cpu_valid,
  input logic       cpu_write,
  input logic       cpu_shared,
  input logic       rsp_valid,
  input logic       rsp_hit,
  input logic [1:0] rsp_state,
  input logic [1:0] bus_cmd,
  input logic       wb_valid,
  input logic       snp_rsp_valid,
  input logic       snp_hit,
  input logic [1:0] snp_cmd
);
  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (rst)
    cpu_valid |=> rsp_valid); // R2
  AST_RD_MISS_STATE: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_hit && !$past(cpu_write)) |->
      (bus_cmd == 2'd1 && rsp_state == ($past(cpu_shared) ? 2'd1 : 2'd2))); // R3
  AST_RD_HIT_QUIET: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_hit && !$past(cpu_write)) |-> bus_cmd == 2'd0); // R4
  AST_WRITE_MOD: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && $past(cpu_write)) |-> rsp_state == 2'd3); // R5
  AST_WRITE_MISS_RDX: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_hit && $past(cpu_write)) |-> bus_cmd == 2'd2); // R6
  AST_FLUSH_NEEDS_HIT: assert property (@(posedge clk) disable iff (rst)
    (snp_cmd != 2'd0) |-> (snp_hit && snp_cmd == 2'd3 && snp_rsp_valid)); // R9
  AST_WB_ON_MISS: assert property (@(posedge clk) disable iff (rst)
    wb_valid |-> (rsp_valid && !rsp_hit)); // R10
endmodule

bind mesi_snoop_ctrl mesi_snoop_ctrl_chk u_chk (.*);

// File: tb/mesi_snoop_ctrl_bench.sv
`timescale 1ns/1ps
module mesi_snoop_ctrl_bench;
  localparam int AW = 12;
  localparam int IW = 3;
  localparam int NL = 1 << IW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cpu_valid = 0, cpu_write = 0, cpu_shared = 0, snp_valid = 0;
  logic [1:0]    snp_op = 0;
  logic [AW-1:0] cpu_addr = 0, snp_addr = 0;
  logic          rsp_valid, rsp_hit, wb_valid, snp_rsp_valid, snp_hit;
  logic [1:0]    rsp_state, bus_cmd, snp_cmd;
  logic [AW-1:0] bus_addr, wb_addr;

  int checks = 0;
  int fails  = 0;
  int        m_st  [NL];
  int        m_tag [NL];

  always #5 clk = ~clk;

  mesi_snoop_ctrl #(.ADDR_W(AW), .IDX_W(IW)) u_mesi_snoop_ctrl (.*);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // one request cycle: model from the requirements, drive, compare next cycle
  task automatic step(input bit cv, input bit cw, input int ctag, input int cidx,
                      input bit sh, input bit sv, input int sop, input int stag,
                      input int sidx);
    bit shit = 0, sflush = 0, chit = 0, ewb = 0, coll;
    int pre = 0, nst = 0, ecmd = 0, wba = 0;
    string lab;
    if (sv && (sop == 1 || sop == 2)) begin
      shit = (m_st[sidx] != 0) && (m_tag[sidx] == stag);
      sflush = shit && m_st[sidx] == 3;
      if (shit) m_st[sidx] = (sop == 1) ? 1 : 0;
    end
    coll = sv && cv && (sidx == cidx) && shit;
    if (cv) begin
      pre  = m_st[cidx];
      chit = (pre != 0) && (m_tag[cidx] == ctag);
      ewb  = !chit && pre == 3;
      wba  = m_tag[cidx] * NL + cidx;
      if (cw) begin
        nst = 3; ecmd = (chit && pre >= 2) ? 0 : 2;
        lab = (ecmd == 0) ? "R5" : "R6";
      end else if (chit) begin
        nst = pre; ecmd = 0; lab = "R4";
      end else begin
        nst = sh ? 1 : 2; ecmd = 1; lab = "R3";
      end
      if (coll) lab = "R11";
      m_st[cidx] = nst; m_tag[cidx] = ctag;
    end
    cpu_valid = cv; cpu_write = cw; cpu_shared = sh;
    cpu_addr = AW'(ctag * NL + cidx);
    snp_valid = sv; snp_op = 2'(sop); snp_addr = AW'(stag * NL + sidx);
    @(negedge clk);
    chk("R2", int'(rsp_valid), int'(cv));
    if (cv) begin
      chk(coll ? "R11" : "R2", int'(rsp_hit), int'(chit));
      chk(lab, int'(rsp_state), nst);
      chk(lab, int'(bus_cmd), ecmd);
      chk("R2", int'(bus_addr), ctag * NL + cidx);
      chk("R10", int'(wb_valid), int'(ewb));
      if (ewb) chk("R10", int'(wb_addr), wba);
    end
    chk("R9", int'(snp_rsp_valid), int'(sv));
    chk(sop == 1 ? "R7" : (sop == 2 ? "R8" : "R9"), int'(snp_hit), int'(shit));
    chk("R9", int'(snp_cmd), sflush ? 3 : 0);
    cpu_valid = 0; snp_valid = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int unsigned x = 32'h1badf00d;
    for (int i = 0; i < NL; i++) begin m_st[i] = 0; m_tag[i] = 0; end
    repeat (3) @(negedge clk);
    rst = 0;
    // R1: outputs after reset
    chk("R1", int'(rsp_valid), 0);
    chk("R1", int'(wb_valid), 0);
    chk("R1", int'(snp_cmd), 0);
    for (int i = 0; i < NL; i++) begin
      step(1, 0, 0, i, 0, 0, 0, 0, 0);
      chk("R1", int'(rsp_hit), 0);
    end
    // directed walk on one line (tag 5, index 2)
    step(0, 0, 0, 0, 0, 1, 2, 0, 0);                  // clean index 0..7 of tag 0
    for (int i = 0; i < NL; i++) step(0, 0, 0, 0, 0, 1, 2, 0, i);
    step(1, 0, 5, 2, 0, 0, 0, 0, 0);                  // R3 miss -> E
    step(1, 0, 5, 2, 0, 0, 0, 0, 0);                  // R4 hit E
    step(1, 1, 5, 2, 0, 0, 0, 0, 0);                  // R5 silent E->M
    step(0, 0, 0, 0, 0, 1, 0, 5, 2);                  // R9 op 0 ignored
    step(0, 0, 0, 0, 0, 1, 3, 5, 2);                  // R9 op 3 ignored
    step(0, 0, 0, 0, 0, 1, 1, 5, 2);                  // R7 + R9 flush, M->S
    step(1, 1, 5, 2, 0, 0, 0, 0, 0);                  // R6 S->M with rdx
    step(1, 0, 6, 2, 1, 0, 0, 0, 0);                  // R10 evict dirty, R3 -> S
    step(1, 1, 6, 2, 0, 1, 2, 6, 2);                  // R11 same-cycle invalidate
    step(0, 0, 0, 0, 0, 1, 2, 6, 2);                  // R8 M->I with flush
    step(1, 0, 6, 2, 0, 0, 0, 0, 0);                  // miss again
    // near-exhaustive sweep, two tags, snoop steered onto core index
    for (int n = 0; n < 4000; n++) begin
      int ci, si;
      x ^= x << 13; x ^= x >> 17; x ^= x << 5;
      ci = int'(x[5:3]);
      si = x[10] ? ci : int'(x[13:11]);
      step(x[0] | x[1], x[2], int'(x[6]), ci, x[15], x[7], int'(x[9:8]),
           int'(x[14]), si);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule